// File: doc/BRIEF.md
# Time-Duplexed Packet Memory Arbiter

This block places one single-port packet store of 256 sixteen-bit words (512 bytes) between two requesters: the host bus port and the USB-side serializer port. Each clock is one memory cycle, and at most one of the two ports is granted in it. A slot register flips on every clock between slot A and slot B. In slot A the host port wins when it requests. In slot B the USB port wins when it requests. An idle owner gives its slot to the other port. The host therefore has priority in general, but the USB port can never wait more than one cycle. To both ports the store behaves like a dual-port RAM, and a host burst of any length leaves the USB side at least half of the cycles.

Each port has a valid/ready handshake. Ready is raised combinationally in the cycle the port is granted. A granted write updates the word at that clock edge. A granted read returns its word on the port's read-data output one cycle later, and that value holds until the next granted read of the same port.

The state machine has two states. SLOT_A is the host-priority slot and SLOT_B is the USB-priority slot. There are two transitions: A_TO_B and B_TO_A. One of them is taken at every clock edge, with no condition attached. Reset forces SLOT_A. Memory contents are undefined after reset.

Top module: `pkt_mem_arbiter`

## Requirements
- R1: While reset is held, the slot is SLOT_A. The first cycle after reset release is an A slot, and both read-data outputs read 0 until the first granted read of that port.
- R2: In an A slot, a host request is granted (host_ready=1, usb_ready=0), even when the USB port is also requesting.
- R3: In an A slot with the host idle, a USB request is granted.
- R4: In a B slot, a USB request is granted (usb_ready=1, host_ready=0), even when the host is also requesting.
- R5: In a B slot with the USB port idle, a host request is granted.
- R6: At most one ready is high in any cycle, and a ready is high only while that port's valid is high.
- R7: A USB request that is held does not wait more than one cycle for its grant, whatever the host does.
- R8: A granted read (we=0) puts mem[addr] on that port's read-data output one cycle after the grant. The output then holds until the port's next granted read.
- R9: A granted write (we=1) stores wdata at addr. A read of the same word in the next cycle, from either port, returns the new value. This includes the boundary addresses 0 and 255.
- R10: The slot alternates A, B, A, ... on every cycle whether or not any port requests.
- R11: With both ports requesting on every cycle, grants alternate host, USB, host, USB, so a host burst of any length and USB traffic proceed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one memory cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request pending |
| host_we | input | 1 | Host request is a write (1) or read (0) |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host granted this cycle |
| host_rdata | output | 16 | Host read data, one cycle after a read grant |
| usb_valid | input | 1 | USB request pending |
| usb_we | input | 1 | USB request is a write (1) or read (0) |
| usb_addr | input | 8 | USB word address |
| usb_wdata | input | 16 | USB write data |
| usb_ready | output | 1 | USB granted this cycle |
| usb_rdata | output | 16 | USB read data, one cycle after a read grant |

## Verification
Grants are combinational, so both readies are due in the same cycle as the request. The bench drives requests at the falling edge and samples the readies one time step later. Read data is due after the rising edge that follows a grant. The bench compares it at the next falling edge, before any new stimulus is applied. The bench tracks the slot itself from a cycle count taken since reset release, and it never looks at the design's slot register. It also counts how long each held USB request waits, to check the one-cycle bound.

// File: rtl/pkt_mem_arb_pkg.sv
package pkt_mem_arb_pkg;
    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_HOST = 2'd1,
        GNT_USB  = 2'd2
    } gnt_e;
endpackage

// File: rtl/slot_fsm.sv
module slot_fsm
    import pkt_mem_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  host_req,
    input  logic  usb_req,
    output slot_e slot,
    output gnt_e  gnt
);
    slot_e slot_nxt;

    // state register: A_TO_B / B_TO_A taken on every edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot <= SLOT_A;
        else        slot <= slot_nxt;
    end

    // next state and grant
    always_comb begin
        slot_nxt = SLOT_A;
        gnt      = GNT_NONE;
        unique case (slot)
            SLOT_A: begin
                slot_nxt = SLOT_B;
                if (host_req)     gnt = GNT_HOST;
                else if (usb_req) gnt = GNT_USB;
            end
            SLOT_B: begin
                slot_nxt = SLOT_A;
                if (usb_req)       gnt = GNT_USB;
                else if (host_req) gnt = GNT_HOST;
            end
            default: begin
                slot_nxt = SLOT_A;
                gnt      = GNT_NONE;
            end
        endcase
    end

    p_a_to_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_A) |=> (slot == SLOT_B));
    p_b_to_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_B) |=> (slot == SLOT_A));
endmodule

// File: rtl/pkt_ram.sv
module pkt_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    q         <= mem[addr];
        end
    end
endmodule

// File: rtl/rd_steer.sv
module rd_steer
    import pkt_mem_arb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gnt_e              gnt,
    input  logic              host_we,
    input  logic              usb_we,
    input  logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] usb_rdata
);
    logic              host_rd_d, usb_rd_d;
    logic [DATA_W-1:0] host_hold, usb_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rd_d <= 1'b0;
            usb_rd_d  <= 1'b0;
            host_hold <= '0;
            usb_hold  <= '0;
        end else begin
            host_rd_d <= (gnt == GNT_HOST) && !host_we;
            usb_rd_d  <= (gnt == GNT_USB)  && !usb_we;
            host_hold <= host_rdata;
            usb_hold  <= usb_rdata;
        end
    end

    always_comb begin
        host_rdata = host_rd_d ? q : host_hold;
        usb_rdata  = usb_rd_d  ? q : usb_hold;
    end

    p_host_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((gnt == GNT_HOST) && !host_we) |=> $stable(host_rdata));
    p_usb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((gnt == GNT_USB) && !usb_we) |=> $stable(usb_rdata));
endmodule

// File: rtl/pkt_mem_arbiter.sv
module pkt_mem_arbiter
    import pkt_mem_arb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              usb_valid,
    input  logic              usb_we,
    input  logic [ADDR_W-1:0] usb_addr,
    input  logic [DATA_W-1:0] usb_wdata,
    output logic              usb_ready,
    output logic [DATA_W-1:0] usb_rdata
);
    slot_e             slot;
    gnt_e              gnt;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_q;

    slot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_req (host_valid),
        .usb_req  (usb_valid),
        .slot     (slot),
        .gnt      (gnt)
    );

    // request mux toward the single port
    always_comb begin
        host_ready = (gnt == GNT_HOST);
        usb_ready  = (gnt == GNT_USB);
        mem_en     = host_ready || usb_ready;
        mem_we     = usb_ready ? usb_we    : host_we;
        mem_addr   = usb_ready ? usb_addr  : host_addr;
        mem_wdata  = usb_ready ? usb_wdata : host_wdata;
    end

    pkt_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .q     (mem_q)
    );

    rd_steer #(.DATA_W(DATA_W)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt        (gnt),
        .host_we    (host_we),
        .usb_we     (usb_we),
        .q          (mem_q),
        .host_rdata (host_rdata),
        .usb_rdata  (usb_rdata)
    );

    p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ready && usb_ready));
    p_ready_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready -> host_valid) && (usb_ready -> usb_valid));
    p_host_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_A && host_valid) |-> host_ready);
    p_usb_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_B && usb_valid) |-> usb_ready);
    p_usb_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_valid && !usb_ready) |=> (!usb_valid || usb_ready));
endmodule

// File: tb/pkt_mem_arbiter_tb.sv
module pkt_mem_arbiter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 0, host_we = 0, usb_valid = 0, usb_we = 0;
    logic [7:0]  host_addr = 0, usb_addr = 0;
    logic [15:0] host_wdata = 0, usb_wdata = 0;
    logic        host_ready, usb_ready;
    logic [15:0] host_rdata, usb_rdata;

    int vectors = 0, errors = 0;
    int k = 0;
    int usb_wait = 0;
    int last_gnt = 0;
    logic [15:0] model [256];
    logic [15:0] exp_h = 16'h0, exp_u = 16'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_mem_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .usb_valid(usb_valid), .usb_we(usb_we), .usb_addr(usb_addr),
        .usb_wdata(usb_wdata), .usb_ready(usb_ready), .usb_rdata(usb_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, k, act, exp);
        end
    endtask

    function automatic int exp_grant(input int slot, input logic hv, input logic uv);
        if (slot == 0) return hv ? 1 : (uv ? 2 : 0);
        return uv ? 2 : (hv ? 1 : 0);
    endfunction

    // one memory cycle: entered and left at a falling edge
    task automatic cycle(input string req);
        int g;
        check("R8 host_rdata", host_rdata, exp_h);
        check("R8 usb_rdata", usb_rdata, exp_u);
        #1;
        g = exp_grant(k % 2, host_valid, usb_valid);
        check({req, " R10 host_ready"}, {15'd0, host_ready}, {15'd0, g == 1});
        check({req, " R10 usb_ready"}, {15'd0, usb_ready}, {15'd0, g == 2});
        check("R6 single grant", {15'd0, host_ready && usb_ready}, 16'd0);
        if (usb_valid && !usb_ready) usb_wait++; else usb_wait = 0;
        check("R7 usb wait", 16'(usb_wait > 1), 16'd0);
        if (g == 1) begin
            if (host_we) model[host_addr] = host_wdata; else exp_h = model[host_addr];
        end else if (g == 2) begin
            if (usb_we) model[usb_addr] = usb_wdata; else exp_u = model[usb_addr];
        end
        last_gnt = g;
        @(posedge clk);
        k++;
        @(negedge clk);
    endtask

    task automatic drive(input logic hv, input logic hw, input logic [7:0] ha, input logic [15:0] hd,
                         input logic uv, input logic uw, input logic [7:0] ua, input logic [15:0] ud);
        host_valid = hv; host_we = hw; host_addr = ha; host_wdata = hd;
        usb_valid = uv; usb_we = uw; usb_addr = ua; usb_wdata = ud;
    endtask

    function automatic logic [7:0] pick_addr();
        int p = $urandom % 18;
        if (p == 16) return 8'd255;
        if (p == 17) return 8'd128;
        return 8'(p);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: first cycle A slot, both valid -> host; outputs 0
        check("R1 host_rdata reset", host_rdata, 16'h0);
        check("R1 usb_rdata reset", usb_rdata, 16'h0);
        drive(1, 1, 8'd0, 16'hA5A5, 1, 1, 8'd255, 16'h5A5A);
        #1;
        check("R1 first slot host", {15'd0, host_ready}, 16'd1);
        cycle("R2");              // A: host writes 0
        cycle("R4");              // B: usb writes 255
        // fill remaining addresses from host (alternating slots, usb idle -> R5)
        for (int a = 0; a < 16; a++) begin
            drive(1, 1, 8'(a), 16'(a * 16'h1111 + 3), 0, 0, 0, 0);
            cycle("R5");
        end
        drive(1, 1, 8'd128, 16'h8080, 0, 0, 0, 0); cycle("R5");
        drive(1, 1, 8'd255, 16'hFFEE, 0, 0, 0, 0); cycle("R9");
        // R9: write then read by other port next cycle
        if (k % 2 != 0) begin drive(0, 0, 0, 0, 0, 0, 0, 0); cycle("R10"); end
        drive(1, 1, 8'd3, 16'hBEEF, 0, 0, 0, 0);  cycle("R9 write");
        drive(0, 0, 0, 0, 1, 0, 8'd3, 0);          cycle("R9 read");
        drive(0, 0, 0, 0, 1, 1, 8'd0, 16'hC0DE);  cycle("R3");
        drive(1, 0, 8'd0, 0, 0, 0, 0, 0);          cycle("R9 read");
        drive(0, 0, 0, 0, 0, 0, 0, 0);            cycle("R8 hold");
        check("R9 read 3 via usb", usb_rdata, 16'hBEEF);
        check("R9 read 0 via host", host_rdata, 16'hC0DE);
        // R11: both request every cycle for a long burst
        for (int i = 0; i < 40; i++) begin
            drive(1, 0, pick_addr(), 0, 1, 0, pick_addr(), 0);
            cycle("R11");
            check("R11 alternation", 16'(last_gnt), (k % 2 == 1) ? 16'd1 : 16'd2);
        end
        // constrained random with held requests
        for (int i = 0; i < 3000; i++) begin
            if (!host_valid || last_gnt == 1) begin
                if (($urandom % 10) < 7) drive(1, 1'($urandom % 2), pick_addr(), 16'($urandom),
                                               usb_valid, usb_we, usb_addr, usb_wdata);
                else host_valid = 0;
            end
            if (!usb_valid || last_gnt == 2) begin
                if (($urandom % 10) < 5) begin
                    usb_valid = 1; usb_we = 1'($urandom % 2);
                    usb_addr = pick_addr(); usb_wdata = 16'($urandom);
                end else usb_valid = 0;
            end
            cycle("R2 R3 R4 R5 random");
        end
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        cycle("R6 idle");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule